// File: doc/BRIEF.md
# SPI TPM Register Transaction Master

This block runs one register access at a time against a TPM-style device on a four-wire SPI bus. A host asks for a read or a write by giving a direction, a byte count from 1 to 64 and a 24-bit register address. The block sends a four-byte frame header. It then holds chip select low and polls the device one byte at a time until the device signals that it is ready. Only then does it move the data. Write bytes are pulled from a byte stream and read bytes are pushed out on a byte stream. Chip select is released after the last byte.

Two rules about device power state govern the start of each access. The first access, and any access that follows a long idle interval, is preceded by a short chip-select pulse that wakes the device. Every access after the first waits, for a bounded time, for the device's ready interrupt. If that wait runs out, the access goes ahead and the condition is flagged. If the device never signals ready within the flow-control timeout, the access is cut short and an error is flagged. In that case a read hands back zero bytes in place of data.

All intervals are parameters counted in system clock cycles. The bus runs in SPI mode 0, MSB first, and SCLK is divided from the system clock.

Top module: `tpm_spi_xact`

## Requirements
- R1: Header byte 0 carries bit 7 = 1 for a read and 0 for a write, bit 6 = 1, and bits 5:0 = `req_len_m1_i`, the byte count minus one. Header bytes 1, 2 and 3 are `req_addr_i[23:16]`, `[15:8]` and `[7:0]`, in that order.
- R2: The bus is SPI mode 0 with MSB first. SCLK is low while CS is high. The block drives MOSI and samples MISO on the SCLK rising edge. Within a byte, rising edges are 2*CLK_DIV system cycles apart.
- R3: After the header, CS stays low and the block sends poll bytes with MOSI all zero until a received byte has bit 0 = 1. The data phase starts with the next byte.
- R4: A write takes exactly `req_len_m1_i`+1 bytes from the write stream, one per cycle in which `wr_valid_i` and `wr_ready_o` are both high. It shifts them out in order. A read takes no write bytes.
- R5: A read delivers `req_len_m1_i`+1 bytes, each shifted in MSB first from MISO, one per `rd_valid_o` pulse.
- R6: CS goes high right after the last data byte, with no extra SCLK edges. `done_o` is high for one cycle while CS is high.
- R7: If FLOW_TO_CYC cycles pass after the header without a ready poll byte, CS is released after the current poll byte and `flow_err_o` = 1 with `done_o`. A read then delivers `req_len_m1_i`+1 bytes of value 0x00. A write takes no write bytes.
- R8: A wake pulse precedes the header on the first access after reset and when at least IDLE_CYC cycles have passed since the previous header started. During the pulse, CS is low for WAKE_LO_CYC cycles with no SCLK edges. CS then stays high for WAKE_HI_CYC cycles before the header. Otherwise no wake pulse is sent.
- R9: Every access after the first waits up to SYNC_TO_CYC cycles before CS falls, for an `irq_i` pulse that arrived while CS was high since the previous header. If no pulse arrives in that time, `sync_to_o` = 1 with `done_o` and the access proceeds. If a pulse arrives, `sync_to_o` = 0.
- R10: `req_ready_o` is high only while the block is idle, which includes after reset. After reset, CS is high, SCLK is low and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_len_m1_i | input | 6 | Byte count minus one |
| req_addr_i | input | 24 | Register address |
| wr_data_i | input | 8 | Write stream byte |
| wr_valid_i | input | 1 | Write stream byte valid |
| wr_ready_o | output | 1 | Write stream byte taken |
| rd_data_o | output | 8 | Read stream byte |
| rd_valid_o | output | 1 | Read stream byte strobe |
| done_o | output | 1 | One-cycle completion pulse |
| flow_err_o | output | 1 | Flow-control timeout, valid with done_o |
| sync_to_o | output | 1 | Ready-interrupt wait timed out, valid with done_o |
| irq_i | input | 1 | Device ready interrupt |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| cs_no | output | 1 | SPI chip select, active low |

## Verification
Each phase ends a fixed number of cycles after its stimulus. A wake pulse holds CS low for exactly WAKE_LO_CYC cycles and then high for exactly WAKE_HI_CYC cycles. SCLK rising edges inside a byte are exactly 2*CLK_DIV cycles apart. The last read byte strobes in the same cycle that `done_o` rises. The bench therefore waits for `done_o` and then one further falling clock edge before it reads its stream counters. It times CS windows by counting falling clock edges, so each length is compared against its exact parameter. The sync timeout is checked as a lower bound on the cycles from the request handshake to the header's CS fall.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_WAKE_LO, ST_WAKE_HI, ST_HDR, ST_POLL, ST_DATA, ST_ZFILL, ST_DONE
  } xact_st_e;

  localparam int unsigned HDR_LAST = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] hdr_byte(input logic rd, input logic [5:0] lm1,
                                          input logic [23:0] addr, input logic [1:0] idx);
    case (idx)
      2'd0:    return {rd, 1'b1, lm1};
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/tpm_spi_byte_eng.sv
module tpm_spi_byte_eng #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int unsigned DW = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);

  logic          busy_q, done_q, sclk_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        tx_q   <= tx_i;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DW'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q ? tx_q[7] : 1'b0;

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);  // R2
  AST_SCLK_REST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);  // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(busy_q));  // R2

endmodule

// File: rtl/tpm_spi_timer.sv
module tpm_spi_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_TMR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));  // R8

endmodule

// File: rtl/tpm_spi_idle_trk.sv
module tpm_spi_idle_trk #(
  parameter int unsigned IDLE_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cs_low_i,
  input  logic irq_i,
  output logic seen_o,
  output logic wake_o,
  output logic irq_seen_o
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);

  logic          seen_q, irq_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      irq_q  <= 1'b0;
      idle_q <= '0;
    end else begin
      if (start_i) begin
        seen_q <= 1'b1;
        idle_q <= '0;
      end else if (idle_q != CW'(IDLE_CYC)) begin
        idle_q <= idle_q + CW'(1);
      end
      if (start_i)                  irq_q <= 1'b0;
      else if (irq_i && !cs_low_i)  irq_q <= 1'b1;
    end
  end

  assign seen_o     = seen_q;
  assign wake_o     = !seen_q || (idle_q == CW'(IDLE_CYC));
  assign irq_seen_o = irq_q;

  AST_IRQ_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !irq_q);  // R9
  AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (seen_q && !wake_o));  // R8

endmodule

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact
  import tpm_spi_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned WAKE_LO_CYC = 100,
  parameter int unsigned WAKE_HI_CYC = 10000,
  parameter int unsigned IDLE_CYC    = 90000000,
  parameter int unsigned FLOW_TO_CYC = 10000000,
  parameter int unsigned SYNC_TO_CYC = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_read_i,
  input  logic [5:0]  req_len_m1_i,
  input  logic [23:0] req_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  output logic [7:0]  rd_data_o,
  output logic        rd_valid_o,
  output logic        done_o,
  output logic        flow_err_o,
  output logic        sync_to_o,
  input  logic        irq_i,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no
);
  localparam int unsigned TMAX = max2(max2(FLOW_TO_CYC, SYNC_TO_CYC), max2(WAKE_LO_CYC, WAKE_HI_CYC));
  localparam int unsigned TW   = $clog2(TMAX + 1);

  xact_st_e    st_q, st_d;
  logic        rd_q, pend_q, flow_err_q, sync_to_q, rd_valid_q;
  logic [5:0]  lm1_q;
  logic [23:0] addr_q;
  logic [1:0]  idx_q;
  logic [6:0]  cnt_q;
  logic [7:0]  rd_data_q;

  logic          eng_start, eng_busy, eng_done;
  logic [7:0]    eng_tx, eng_rx;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          hdr_go, sync_miss, cs_low, last_byte;
  logic          seen, wake, irq_seen;

  assign cs_low    = (st_q == ST_WAKE_LO) || (st_q == ST_HDR) || (st_q == ST_POLL) || (st_q == ST_DATA);
  assign last_byte = (cnt_q == {1'b0, lm1_q});

  always_comb begin
    case (st_q)
      ST_HDR:  eng_tx = hdr_byte(rd_q, lm1_q, addr_q, idx_q);
      ST_DATA: eng_tx = rd_q ? 8'h00 : wr_data_i;
      default: eng_tx = 8'h00;
    endcase
  end

  assign eng_start  = pend_q && !eng_busy && ((st_q != ST_DATA) || rd_q || wr_valid_i);
  assign wr_ready_o = (st_q == ST_DATA) && pend_q && !eng_busy && !rd_q;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    hdr_go    = 1'b0;
    sync_miss = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load = 1'b1;
        if (seen) begin
          st_d    = ST_SYNC;
          tmr_val = TW'(SYNC_TO_CYC - 1);
        end else begin
          st_d    = ST_WAKE_LO;
          tmr_val = TW'(WAKE_LO_CYC - 1);
        end
      end
      ST_SYNC: if (irq_seen || tmr_exp) begin
        sync_miss = !irq_seen;
        if (wake) begin
          st_d     = ST_WAKE_LO;
          tmr_load = 1'b1;
          tmr_val  = TW'(WAKE_LO_CYC - 1);
        end else begin
          st_d   = ST_HDR;
          hdr_go = 1'b1;
        end
      end
      ST_WAKE_LO: if (tmr_exp) begin
        st_d     = ST_WAKE_HI;
        tmr_load = 1'b1;
        tmr_val  = TW'(WAKE_HI_CYC - 1);
      end
      ST_WAKE_HI: if (tmr_exp) begin
        st_d   = ST_HDR;
        hdr_go = 1'b1;
      end
      ST_HDR: if (eng_done && idx_q == 2'(HDR_LAST)) begin
        st_d     = ST_POLL;
        tmr_load = 1'b1;
        tmr_val  = TW'(FLOW_TO_CYC - 1);
      end
      ST_POLL: if (eng_done) begin
        if (eng_rx[0])     st_d = ST_DATA;
        else if (tmr_exp)  st_d = rd_q ? ST_ZFILL : ST_DONE;
      end
      ST_DATA:  if (eng_done && last_byte) st_d = ST_DONE;
      ST_ZFILL: if (last_byte) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rd_q       <= 1'b0;
      lm1_q      <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      flow_err_q <= 1'b0;
      sync_to_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      st_q       <= st_d;
      rd_valid_q <= 1'b0;
      if (eng_start) pend_q <= 1'b0;
      if (hdr_go) begin
        idx_q  <= '0;
        pend_q <= 1'b1;
      end
      if (sync_miss) sync_to_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          rd_q       <= req_read_i;
          lm1_q      <= req_len_m1_i;
          addr_q     <= req_addr_i;
          cnt_q      <= '0;
          flow_err_q <= 1'b0;
          sync_to_q  <= 1'b0;
        end
        ST_HDR: if (eng_done) begin
          pend_q <= 1'b1;
          if (idx_q != 2'(HDR_LAST)) idx_q <= idx_q + 2'd1;
        end
        ST_POLL: if (eng_done) begin
          if (eng_rx[0] || !tmr_exp) pend_q <= 1'b1;
          else                       flow_err_q <= 1'b1;
        end
        ST_DATA: if (eng_done) begin
          cnt_q <= cnt_q + 7'd1;
          if (rd_q) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= eng_rx;
          end
          if (!last_byte) pend_q <= 1'b1;
        end
        ST_ZFILL: begin
          cnt_q      <= cnt_q + 7'd1;
          rd_valid_q <= 1'b1;
          rd_data_q  <= 8'h00;
        end
        default: ;
      endcase
    end
  end

  tpm_spi_byte_eng #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .tx_i   (eng_tx),
    .miso_i (miso_i),
    .busy_o (eng_busy),
    .done_o (eng_done),
    .rx_o   (eng_rx),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  tpm_spi_timer #(.W(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  tpm_spi_idle_trk #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (hdr_go),
    .cs_low_i  (cs_low),
    .irq_i     (irq_i),
    .seen_o    (seen),
    .wake_o    (wake),
    .irq_seen_o(irq_seen)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign cs_no       = !cs_low;
  assign flow_err_o  = flow_err_q;
  assign sync_to_o   = sync_to_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;

  AST_SCLK_QUIET_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);  // R2
  AST_WR_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (!rd_q && !cs_no));  // R4
  AST_RD_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_q);  // R5
  AST_DONE_CS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !req_ready_o));  // R6
  AST_FAIL_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && flow_err_o) |-> (rd_data_o == 8'h00));  // R7
  AST_DATA_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !flow_err_o) |-> (cnt_q == {1'b0, lm1_q} + 7'd1));  // R4

endmodule

// File: tb/tpm_spi_xact_test.sv
module tpm_spi_xact_test;
  localparam int DIV = 2, WLO = 10, WHI = 20, IDLE = 6000, FLOWTO = 400, SYNCTO = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_read = 1'b0, irq = 1'b0;
  logic [5:0]  req_lm1 = '0;
  logic [23:0] req_addr = '0;
  logic        req_ready, wr_ready, rd_valid, done, flow_err, sync_to, sclk, mosi, miso, cs_n;
  logic [7:0]  wr_data, rd_data;

  tpm_spi_xact #(.CLK_DIV(DIV), .WAKE_LO_CYC(WLO), .WAKE_HI_CYC(WHI), .IDLE_CYC(IDLE),
                 .FLOW_TO_CYC(FLOWTO), .SYNC_TO_CYC(SYNCTO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_read_i(req_read), .req_len_m1_i(req_lm1), .req_addr_i(req_addr),
    .wr_data_i(wr_data), .wr_valid_i(1'b1), .wr_ready_o(wr_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done), .flow_err_o(flow_err),
    .sync_to_o(sync_to), .irq_i(irq), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n));

  int nchk = 0, nfail = 0, ncyc = 0;
  bit finished = 0;

  function automatic logic [7:0] wpat(input int i);  return 8'h3C + 8'(i * 5);  endfunction
  function automatic logic [7:0] rpat(input int i);  return 8'hA5 ^ 8'(i * 13); endfunction

  // device model
  int stall_cfg = 0, dbytes = 0, dbit = 0;
  logic [7:0] dsh = '0, dcur = '0;
  logic [7:0] cap [128];
  int r_cyc [2];
  function automatic logic [7:0] dev_byte(input int j);
    if (j < 4)                  return 8'h00;
    else if (j < 4 + stall_cfg) return 8'hFE;
    else if (j == 4 + stall_cfg) return 8'h01;
    else                        return rpat(j - 5 - stall_cfg);
  endfunction
  assign miso = cs_n ? 1'b0 : dcur[3'(7 - dbit)];

  always @(negedge cs_n) begin
    dbytes = 0; dbit = 0; dcur = dev_byte(0);
  end
  always @(posedge sclk) begin
    if (dbytes == 0 && dbit < 2) r_cyc[dbit] = ncyc;
    dsh = {dsh[6:0], mosi};
    dbit++;
    if (dbit == 8) begin
      if (dbytes < 128) cap[dbytes] = dsh;
      dbytes++; dbit = 0; dcur = dev_byte(dbytes);
    end
  end

  // write stream
  int widx = 0, wbase = 0;
  assign wr_data = wpat(widx - wbase);
  always @(posedge clk) if (wr_ready) widx <= widx + 1;

  // monitor
  int rcnt = 0, wake_n = 0, wake_len = 0, low_run = 0, hi_run = 0, hi_gap = 0, fall_cyc = 0, irq_cd = 0;
  bit irq_en = 1, cs_prev = 1;
  logic [7:0] rbuf [64];
  always @(negedge clk) begin
    ncyc++;
    if (rd_valid) begin if (rcnt < 64) rbuf[rcnt] = rd_data; rcnt++; end
    if (!cs_n) begin
      if (cs_prev) begin hi_gap = hi_run; fall_cyc = ncyc; low_run = 0; end
      low_run++;
    end else begin
      if (!cs_prev) begin
        hi_run = 0;
        if (dbytes == 0) begin wake_n++; wake_len = low_run; end
        else if (irq_en) irq_cd = 5;
      end
      hi_run++;
    end
    cs_prev = cs_n;
    if (irq_cd > 0) begin irq_cd--; irq = (irq_cd == 0); end else irq = 1'b0;
    if (ncyc == 150000 && !finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", ncyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int hs_cyc, got_flow, got_sync, got_bytes, got_w;
  task automatic run(input logic rd, input logic [5:0] lm1, input logic [23:0] addr, input int stall);
    stall_cfg = stall; rcnt = 0; wake_n = 0; wbase = widx;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_lm1 = lm1; req_addr = addr;
    while (!req_ready) @(negedge clk);
    hs_cyc = ncyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(cs_n == 1'b1, "R6", "cs at done", cs_n, 1);
    got_flow = flow_err; got_sync = sync_to; got_bytes = dbytes;
    @(negedge clk);
    got_w = widx - wbase;
  endtask

  logic [39:0] VECS [6] = '{
    {1'b0, 7'd0,  24'hD40018, 8'd0},
    {1'b1, 7'd3,  24'hD40F00, 8'd2},
    {1'b0, 7'd63, 24'hD40024, 8'd1},
    {1'b1, 7'd63, 24'hD40024, 8'd0},
    {1'b1, 7'd0,  24'hD40000, 8'd5},
    {1'b0, 7'd2,  24'h123456, 8'd3}
  };

  initial begin
    #1;
    chk(cs_n == 1'b1 && sclk == 1'b0, "R10", "reset cs/sclk", {cs_n, sclk}, 2);
    chk(req_ready == 1'b1 && done == 1'b0, "R10", "reset ready/done", {req_ready, done}, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && cs_n == 1'b1, "R10", "idle after reset", {req_ready, cs_n}, 3);

    for (int v = 0; v < 6; v++) begin
      logic rd; logic [5:0] lm1; logic [23:0] a; int st, n; bit ok;
      rd = VECS[v][39]; lm1 = VECS[v][37:32]; a = VECS[v][31:8]; st = int'(VECS[v][7:0]);
      n = int'(lm1) + 1;
      run(rd, lm1, a, st);
      chk({cap[0], cap[1], cap[2], cap[3]} == {rd, 1'b1, lm1, a}, "R1", "header",
          int'(cap[0]), int'({rd, 1'b1, lm1}));
      chk(got_bytes == 5 + st + n, "R6", "bus bytes", got_bytes, 5 + st + n);
      ok = 1; for (int j = 4; j <= 4 + st; j++) if (cap[j] != 8'h00) ok = 0;
      chk(ok, "R3", "poll mosi zero", ok, 1);
      if (rd) begin
        ok = 1; for (int i = 0; i < n; i++) if (rbuf[i] != rpat(i)) ok = 0;
        chk(rcnt == n && ok, "R5", "read data", rcnt, n);
        chk(got_w == 0, "R4", "read takes no write bytes", got_w, 0);
      end else begin
        ok = 1; for (int i = 0; i < n; i++) if (cap[5 + st + i] != wpat(i)) ok = 0;
        chk(got_w == n && ok, "R4", "write data", got_w, n);
      end
      chk(got_flow == 0 && got_sync == 0, "R9", "flags clear", {got_flow, got_sync}, 0);
      chk(wake_n == (v == 0 ? 1 : 0), "R8", "wake count", wake_n, v == 0 ? 1 : 0);
      if (v == 0) begin
        chk(wake_len == WLO, "R8", "wake low len", wake_len, WLO);
        chk(hi_gap == WHI, "R8", "wake gap", hi_gap, WHI);
        chk(r_cyc[1] - r_cyc[0] == 2 * DIV, "R2", "sclk period", r_cyc[1] - r_cyc[0], 2 * DIV);
      end
    end

    // flow-control timeout, read and write
    run(1'b1, 6'd2, 24'hD40018, 100);
    chk(got_flow == 1, "R7", "read flow err", got_flow, 1);
    chk(got_bytes > 4 && got_bytes < 104, "R7", "cut short", got_bytes, 104);
    chk(rcnt == 3 && rbuf[0] == 0 && rbuf[1] == 0 && rbuf[2] == 0, "R7", "zero fill", rcnt, 3);
    run(1'b0, 6'd1, 24'hD40024, 100);
    chk(got_flow == 1 && got_w == 0, "R7", "write flow err, no data", got_w, 0);

    // ready-interrupt wait
    repeat (20) @(negedge clk);
    irq_en = 0;
    run(1'b1, 6'd0, 24'hD40F04, 0);
    chk(got_sync == 0 && fall_cyc - hs_cyc < SYNCTO, "R9", "irq present", got_sync, 0);
    run(1'b1, 6'd0, 24'hD40F04, 0);
    chk(got_sync == 1, "R9", "sync timeout flag", got_sync, 1);
    chk(fall_cyc - hs_cyc >= SYNCTO, "R9", "sync wait len", fall_cyc - hs_cyc, SYNCTO);
    irq_en = 1;

    // long idle forces wake
    repeat (IDLE + 500) @(negedge clk);
    run(1'b1, 6'd3, 24'hD40F00, 0);
    chk(wake_n == 1 && wake_len == WLO, "R8", "idle wake", wake_n, 1);
    chk(hi_gap == WHI, "R8", "idle wake gap", hi_gap, WHI);
    chk(rcnt == 4 && rbuf[3] == rpat(3), "R5", "read after wake", rcnt, 4);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule